// File: doc/BRIEF.md
# Multi-Bank Coherent Clock Divider

This block turns one fast source clock into three banks of divided clock outputs and one separate feedback clock. Each bank has a select input that picks one of two divide ratios. The feedback clock has a two-bit select that picks one of four ratios. A single range bit doubles every ratio at once. It is the digital back end of a clock generator: a fast clock comes in, and the banks go out to pad drivers and on to the rest of the board. The feedback output is meant to return to a loop that compares phase.

All dividers run from one common clock and are cleared together. Their rising edges therefore stay aligned, so integer and 3:2 frequency relationships between banks hold edge for edge. A bypass input swaps the fast clock for one of two reference clocks, for test. The dividing behaviour stays the same in bypass.

A run input can park the three banks low without disturbing the feedback clock. This gating is glitch-free. The master reset clears all divider state and drops the drive enable, which tells the pad drivers to float the pins.

Top module: `clkdiv_banks`

## Requirements
- R1: Banks A and B divide the source clock by 4 (select 0) or 8 (select 1) when `range_hi` is 0, and by 8 (select 0) or 16 (select 1) when `range_hi` is 1.
- R2: Bank C divides the source clock by 8 (select 0) or 12 (select 1) when `range_hi` is 0, and by 16 or 24 when `range_hi` is 1.
- R3: With `range_hi` at 0, `sel_fb` codes 00, 01, 10 and 11 divide the feedback clock by 8, 16, 12 and 24. With `range_hi` at 1, the same codes divide by 16, 32, 24 and 48.
- R4: Every output is high as soon as reset is released. The first rising source edge after release counts as edge 1. An output of ratio D stays high through edge D/2 - 1, falls on edge D/2, and rises again on edge D. This repeats, so the duty cycle is 50% and all rising edges fall on multiples of D counted from release.
- R5: While `banks_run` is 0, after a bounded settling time, every bit of `out_a`, `out_b` and `out_c` reads 0. `out_fb` keeps following R3/R4 without interruption.
- R6: Stopping and restarting never shortens a pulse. Every high pulse on a bank lasts exactly D/2 source cycles, and gating changes state only during a low phase of that bank. After restart the bank output again matches the R4 pattern exactly.
- R7: While `rst_n` is 0, `drive_en` reads 0 and every clock output reads 0. This takes effect at once, without waiting for a clock edge.
- R8: Holding `rst_n` low across at least one rising edge of the selected source clock clears all divider state. After release the outputs restart from the R4 pattern at edge 0, whatever phase they had before.
- R9: With `bypass` at 1, the dividers count `ref0` (when `ref_sel` is 0) or `ref1` (when `ref_sel` is 1) instead of `clk_fast`, with the same ratios as in R1 to R4. With `bypass` at 0, `clk_fast` is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast source clock in normal operation |
| ref0 | input | 1 | First reference clock, used in bypass when ref_sel is 0 |
| ref1 | input | 1 | Second reference clock, used in bypass when ref_sel is 1 |
| bypass | input | 1 | 1 selects a reference clock as the divider source |
| ref_sel | input | 1 | Reference pick for bypass: 0 = ref0, 1 = ref1 |
| range_hi | input | 1 | Pre-scale: 0 = by 2, 1 = by 4, applied to all ratios |
| sel_a | input | 1 | Bank A ratio select |
| sel_b | input | 1 | Bank B ratio select |
| sel_c | input | 1 | Bank C ratio select |
| sel_fb | input | 2 | Feedback ratio select |
| banks_run | input | 1 | 1 = banks running, 0 = banks parked low (asynchronous) |
| rst_n | input | 1 | Master reset and output disable, active low |
| out_a | output | A_W (5) | Bank A clock outputs |
| out_b | output | B_W (5) | Bank B clock outputs |
| out_c | output | C_W (4) | Bank C clock outputs |
| out_fb | output | 1 | Feedback clock output, never gated by banks_run |
| drive_en | output | 1 | 1 = pad drivers active, 0 = float the output pins |

## Verification
The bench counts edges of whichever source clock is selected. It compares every output bit against the ideal divided waveform on every cycle. A mis-decoded ratio, a counter that is not cleared by a mid-period reset, or a bypass path that counts the wrong reference drifts off that waveform within one period. A stop and restart is run under several ratios, including both bypass references. During it the bench measures every bank high pulse and keeps checking the feedback clock. Gating that acts during a high phase shows up as a short pulse, and gating that reaches the feedback clock breaks its waveform. A reset asserted part-way through a period checks that the outputs drop at once and that the next release restarts all banks in phase.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
// Shared constants and ratio decoding for the multi-bank clock divider.
// Every decoder returns half of the total divide ratio, which is the number
// of source cycles each output spends in one phase. Assumes all ratios even.
package clkdiv_pkg;
    localparam int HALF_W    = 5;          // holds half-ratios up to 24
    localparam int NUM_BANKS = 3;          // gated banks A, B, C
    localparam int NUM_DIV   = NUM_BANKS + 1; // plus the feedback divider
    localparam int BANK_A    = 0;
    localparam int BANK_B    = 1;
    localparam int BANK_C    = 2;
    localparam int BANK_FB   = 3;

    typedef logic [HALF_W-1:0] half_t;

    // Half-ratio for banks A and B: factor 2 or 4, doubled in the high range
    function automatic half_t half_ab(input logic rng, input logic sel);
        half_t f;
        f = sel ? half_t'(4) : half_t'(2);
        return rng ? half_t'(f << 1) : f;
    endfunction

    // Half-ratio for bank C: factor 4 or 6, doubled in the high range
    function automatic half_t half_c(input logic rng, input logic sel);
        half_t f;
        f = sel ? half_t'(6) : half_t'(4);
        return rng ? half_t'(f << 1) : f;
    endfunction

    // Half-ratio for feedback: high bit picks 4 or 6, low bit doubles
    function automatic half_t half_fb(input logic rng, input logic [1:0] sel);
        half_t f;
        f = sel[1] ? half_t'(6) : half_t'(4);
        if (sel[0]) f = half_t'(f << 1);
        return rng ? half_t'(f << 1) : f;
    endfunction
endpackage

// File: rtl/clkdiv_src_mux.sv
`timescale 1ns/1ps
// Source clock selection for the dividers.
// Picks the fast clock in normal use or one reference clock in bypass.
// Assumes the selects only change while the dividers are held in reset,
// so a switching glitch can never reach running divider state.
module clkdiv_src_mux (
    input  logic clk_fast,
    input  logic ref0,
    input  logic ref1,
    input  logic bypass,
    input  logic ref_sel,
    output logic div_clk
);
    logic ref_clk;

    // Choose the reference, then choose between reference and fast clock
    always_comb begin
        ref_clk = ref_sel ? ref1 : ref0;
        div_clk = bypass ? ref_clk : clk_fast;
    end
endmodule

// File: rtl/clkdiv_counter.sv
`timescale 1ns/1ps
// Half-period counter with a phase toggle: one divided clock.
// Counts 0..half-1 and toggles the phase on the wrap. Reset loads phase high
// with the count at zero, so rising edges fall on multiples of the full
// ratio counted from release. Assumes half >= 2 and static outside reset.
module clkdiv_counter #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] half,
    output logic         phase,
    output logic         wrap
);
    logic [W-1:0] cnt;

    // Last count of the current phase (>= tolerates a smaller half)
    assign wrap = (cnt >= half - 1'b1);

    // Advance the count and flip the phase at the end of each half period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            phase <= 1'b1;
        end else if (wrap) begin
            cnt   <= '0;
            phase <= ~phase;
        end else begin
            cnt   <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/clkdiv_gate.sv
`timescale 1ns/1ps
// Glitch-free stop gate for one bank.
// The enable follows the synchronized run request, but only on an edge where
// the bank phase is low both before and after, so a high pulse is never cut
// and never starts short. Assumes run_s is already in the divider domain.
module clkdiv_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic run_s,
    input  logic phase,
    input  logic wrap,
    output logic en,
    output logic gated
);
    // Update the enable only inside a low phase that is not ending
    always_ff @(posedge clk) begin
        if (!rst_n)             en <= 1'b1;
        else if (!phase && !wrap) en <= run_s;
    end

    assign gated = phase & en;
endmodule

// File: rtl/clkdiv_banks.sv
`timescale 1ns/1ps
// Multi-bank coherent clock divider, top level.
// One source clock (fast or reference in bypass) drives four dividers that
// share reset, so all outputs stay phase-aligned. Three banks pass through
// stop gates; the feedback clock does not. rst_n low forces outputs low and
// drops drive_en at once; divider state clears on the next source edge.
// Assumes selects are changed only while rst_n is low.
module clkdiv_banks
    import clkdiv_pkg::*;
#(
    parameter int A_W = 5,
    parameter int B_W = 5,
    parameter int C_W = 4
) (
    input  logic           clk_fast,
    input  logic           ref0,
    input  logic           ref1,
    input  logic           bypass,
    input  logic           ref_sel,
    input  logic           range_hi,
    input  logic           sel_a,
    input  logic           sel_b,
    input  logic           sel_c,
    input  logic [1:0]     sel_fb,
    input  logic           banks_run,
    input  logic           rst_n,
    output logic [A_W-1:0] out_a,
    output logic [B_W-1:0] out_b,
    output logic [C_W-1:0] out_c,
    output logic           out_fb,
    output logic           drive_en
);
    logic                       div_clk;
    half_t [NUM_DIV-1:0]        halves;
    logic  [NUM_DIV-1:0]        phase;
    logic  [NUM_DIV-1:0]        wrap;
    logic  [NUM_BANKS-1:0]      en;
    logic  [NUM_BANKS-1:0]      gated;
    logic                       run_m;
    logic                       run_s;

    clkdiv_src_mux u_mux (
        .clk_fast (clk_fast),
        .ref0     (ref0),
        .ref1     (ref1),
        .bypass   (bypass),
        .ref_sel  (ref_sel),
        .div_clk  (div_clk)
    );

    // Decode every divider's half-ratio from the range bit and its select
    always_comb begin
        halves[BANK_A]  = half_ab(range_hi, sel_a);
        halves[BANK_B]  = half_ab(range_hi, sel_b);
        halves[BANK_C]  = half_c(range_hi, sel_c);
        halves[BANK_FB] = half_fb(range_hi, sel_fb);
    end

    // Two-stage synchronizer bringing the run request into the divider domain
    always_ff @(posedge div_clk) begin
        if (!rst_n) begin
            run_m <= 1'b1;
            run_s <= 1'b1;
        end else begin
            run_m <= banks_run;
            run_s <= run_m;
        end
    end

    for (genvar k = 0; k < NUM_DIV; k++) begin : g_div
        clkdiv_counter #(.W(HALF_W)) u_cnt (
            .clk   (div_clk),
            .rst_n (rst_n),
            .half  (halves[k]),
            .phase (phase[k]),
            .wrap  (wrap[k])
        );
    end

    for (genvar k = 0; k < NUM_BANKS; k++) begin : g_gate
        clkdiv_gate u_gate (
            .clk   (div_clk),
            .rst_n (rst_n),
            .run_s (run_s),
            .phase (phase[k]),
            .wrap  (wrap[k]),
            .en    (en[k]),
            .gated (gated[k])
        );
    end

    // Fan out each bank and force everything low while disabled
    assign drive_en = rst_n;
    assign out_a    = {A_W{gated[BANK_A] & rst_n}};
    assign out_b    = {B_W{gated[BANK_B] & rst_n}};
    assign out_c    = {C_W{gated[BANK_C] & rst_n}};
    assign out_fb   = phase[BANK_FB] & rst_n;
endmodule

// File: rtl/clkdiv_banks_chk.sv
`timescale 1ns/1ps
// Assertion checker for clkdiv_banks, attached by bind.
// Observes the divider phases, the gate enables and the ports.
module clkdiv_banks_chk
    import clkdiv_pkg::*;
#(
    parameter int A_W = 5,
    parameter int B_W = 5,
    parameter int C_W = 4
) (
    input logic                 div_clk,
    input logic                 rst_n,
    input logic                 sel_a,
    input logic                 sel_c,
    input logic [NUM_DIV-1:0]   phase,
    input logic [NUM_BANKS-1:0] en,
    input logic [A_W-1:0]       out_a,
    input logic [B_W-1:0]       out_b,
    input logic [C_W-1:0]       out_c,
    input logic                 out_fb,
    input logic                 drive_en
);
    // R7: disabled outputs read low with the drive enable dropped
    always_comb begin
        if (rst_n === 1'b0) begin
            p_off_r7: assert (drive_en == 1'b0 && out_fb == 1'b0 &&
                              out_a == '0 && out_b == '0 && out_c == '0);
        end
    end

    // R6: a gate enable changes only while its bank stays low
    for (genvar k = 0; k < NUM_BANKS; k++) begin : g_gate_chk
        p_gate_low_r6: assert property (@(posedge div_clk) disable iff (!rst_n)
            !$stable(en[k]) |-> (!$past(phase[k]) && !phase[k]));
    end

    // R4: a shortest bank A ratio divides every feedback ratio, so edges coincide
    p_fb_align_r4: assert property (@(posedge div_clk) disable iff (!rst_n)
        (!sel_a && $rose(phase[BANK_FB])) |-> $rose(phase[BANK_A]));

    // R2: bank C at its smaller ratio rises together with bank A at its smaller ratio
    p_c_align_r2: assert property (@(posedge div_clk) disable iff (!rst_n)
        (!sel_a && !sel_c && $rose(phase[BANK_C])) |-> $rose(phase[BANK_A]));
endmodule

bind clkdiv_banks clkdiv_banks_chk #(.A_W(A_W), .B_W(B_W), .C_W(C_W)) u_chk (.*);

// File: tb/clkdiv_banks_test.sv
`timescale 1ns/1ps
module clkdiv_banks_test;
    localparam int A_W = 5;
    localparam int B_W = 5;
    localparam int C_W = 4;

    logic clk_fast = 1'b0, ref0 = 1'b0, ref1 = 1'b0;
    always #2.5 clk_fast = ~clk_fast;   // 200 MHz
    always #6   ref0     = ~ref0;
    always #9   ref1     = ~ref1;

    logic bypass = 0, ref_sel = 0, range_hi = 0;
    logic sel_a = 0, sel_b = 0, sel_c = 0, banks_run = 1, rst_n = 0;
    logic [1:0] sel_fb = 2'b00;
    logic [A_W-1:0] out_a;
    logic [B_W-1:0] out_b;
    logic [C_W-1:0] out_c;
    logic out_fb, drive_en;

    clkdiv_banks #(.A_W(A_W), .B_W(B_W), .C_W(C_W)) uut (
        .clk_fast(clk_fast), .ref0(ref0), .ref1(ref1), .bypass(bypass),
        .ref_sel(ref_sel), .range_hi(range_hi), .sel_a(sel_a), .sel_b(sel_b),
        .sel_c(sel_c), .sel_fb(sel_fb), .banks_run(banks_run), .rst_n(rst_n),
        .out_a(out_a), .out_b(out_b), .out_c(out_c), .out_fb(out_fb),
        .drive_en(drive_en)
    );

    int compared = 0, mismatched = 0;
    int n;                 // source edges since reset release
    int half_e [4];        // expected half-ratios: A, B, C, FB
    int hi_run [3];
    bit prev   [3];
    bit armed  [3];
    bit done = 0;

    // Expected half-ratio from R1, R2, R3
    function automatic int exp_half(int bank, bit rng, logic [1:0] sel);
        int f;
        case (bank)
            0, 1:    f = sel[0] ? 4 : 2;
            2:       f = sel[0] ? 6 : 4;
            default: f = (sel[1] ? 6 : 4) * (sel[0] ? 2 : 1);
        endcase
        return rng ? 2 * f : f;
    endfunction

    // Expected level after edge k (R4)
    function automatic bit exp_level(int k, int h);
        return ((k / h) % 2) == 0;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s at edge %0d: actual %0d expected %0d", tag, n, act, exp);
        end
    endtask

    // Wait for the next edge of the selected source, then step off it
    task automatic src_edge();
        if (!bypass)       @(posedge clk_fast);
        else if (!ref_sel) @(posedge ref0);
        else               @(posedge ref1);
        #1;
    endtask

    // mode 0: full waveform check; 1: transition (pulse widths only); 2: banks parked
    task automatic check_all(int mode);
        string x9;
        bit e [4];
        bit v [3];
        x9 = bypass ? " R9" : "";
        for (int k = 0; k < 4; k++) e[k] = exp_level(n, half_e[k]);
        chk(out_fb === e[3], {"R3 R4 R5", x9, " fb"}, int'(out_fb), int'(e[3]));
        if (mode == 0) begin
            chk(out_a === {A_W{e[0]}}, {"R1 R4", x9, " bank A"}, int'(out_a), e[0] ? 31 : 0);
            chk(out_b === {B_W{e[1]}}, {"R1 R4", x9, " bank B"}, int'(out_b), e[1] ? 31 : 0);
            chk(out_c === {C_W{e[2]}}, {"R2 R4", x9, " bank C"}, int'(out_c), e[2] ? 15 : 0);
        end else if (mode == 2) begin
            chk(out_a == '0 && out_b == '0 && out_c == '0, "R5 parked banks",
                int'(out_a) + int'(out_b) + int'(out_c), 0);
        end
        v[0] = out_a[0]; v[1] = out_b[0]; v[2] = out_c[0];
        for (int k = 0; k < 3; k++) begin
            if (v[k] && !prev[k]) begin
                armed[k] = 1; hi_run[k] = 1;
            end else if (v[k]) begin
                hi_run[k]++;
            end else if (prev[k] && armed[k]) begin
                chk(hi_run[k] == half_e[k], $sformatf("R6 pulse width bank %0d", k),
                    hi_run[k], half_e[k]);
            end
            prev[k] = v[k];
        end
    endtask

    task automatic observe(int cycles, int mode);
        for (int i = 0; i < cycles; i++) begin
            src_edge();
            n++;
            check_all(mode);
        end
    endtask

    task automatic run_cfg(bit bp, bit rs, bit rng, bit sa, bit sb, bit sc, logic [1:0] sf);
        rst_n = 0;
        #1;
        chk(drive_en == 0 && out_fb == 0 && out_a == '0 && out_b == '0 && out_c == '0,
            "R7 disabled at once", int'(drive_en) + int'(out_fb) + int'(out_a), 0);
        bypass = bp; ref_sel = rs; range_hi = rng;
        sel_a = sa; sel_b = sb; sel_c = sc; sel_fb = sf; banks_run = 1;
        repeat (3) src_edge();
        chk(drive_en == 0 && out_c == '0, "R7 held disabled", int'(drive_en), 0);
        half_e[0] = exp_half(0, rng, {1'b0, sa});
        half_e[1] = exp_half(1, rng, {1'b0, sb});
        half_e[2] = exp_half(2, rng, {1'b0, sc});
        half_e[3] = exp_half(3, rng, sf);
        rst_n = 1;
        n = 0;
        for (int k = 0; k < 3; k++) begin prev[k] = 1; armed[k] = 0; hi_run[k] = 0; end
        #0.1;
        chk(drive_en == 1 && out_a == '1 && out_b == '1 && out_c == '1 && out_fb == 1,
            "R8 restart high", int'(out_a), 31);
        check_all(0);
    endtask

    task automatic stop_test();
        observe(30, 1);
        banks_run = 0;
        observe(40, 1);
        observe(50, 2);
        banks_run = 1;
        observe(40, 1);
        observe(101, 0);
    endtask

    initial begin
        void'($urandom(32'd4242));
        // Directed: smallest ratios, then stop/restart (R5, R6)
        run_cfg(0, 0, 0, 0, 0, 0, 2'b00);
        observe(97, 0);
        stop_test();
        // Largest ratios, reset lands mid-period (R8)
        run_cfg(0, 0, 1, 1, 1, 1, 2'b11);
        observe(203, 0);
        // Mixed ratios in the low range
        run_cfg(0, 0, 0, 0, 1, 1, 2'b10);
        observe(150, 0);
        // Bypass via ref0 and ref1 (R9)
        run_cfg(1, 0, 0, 0, 1, 1, 2'b01);
        observe(90, 0);
        run_cfg(1, 1, 1, 0, 0, 1, 2'b10);
        observe(120, 0);
        stop_test();
        // Random configurations
        for (int t = 0; t < 12; t++) begin
            int unsigned r;
            r = $urandom;
            run_cfg(r[0], r[1], r[2], r[3], r[4], r[5], r[7:6]);
            observe(60 + int'(r[15:8] % 8'd120), 0);
            if (r[16]) stop_test();
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #3000000;
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule